// File: doc/BRIEF.md
# Board Configuration Transaction Controller

This block gives software a three-register window for reaching board configuration devices: oscillators on the motherboard, oscillators on the first daughterboard, and voltage sensors. Software places an operand in the data register. It then writes a command word to the control register with the launch bit set. The command word names the controller, the function, the site, the stack position and the device. The block decodes the word and carries out the read or write against its internal tables. It then records completion, and an error flag when the target is not supported, in the status register.

A successful read leaves its result in the data register. A write takes its value from the data register. Shutdown and reboot commands leave the block as one-cycle request pulses. A parameter removes the whole feature. In that variant, the three offsets read as zero and ignore writes.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: After reset the data, control and status registers read zero. The motherboard oscillators hold 50,000,000, 23,750,000, then 24,000,000 for entries 2 to 5. Each daughterboard oscillator holds its own reset parameter. Neither request pulse is high.
- R2: The control register lives at byte offset 0xA4. A write stores the word with bits 31, 19 and 18 forced to zero, so bit 31 always reads back as zero. A control write with bit 31 clear leaves the status register unchanged.
- R3: The status register lives at 0xA8. A control write with bit 31 (launch) set makes the status read 1 (bit 0, done) from the following cycle. It reads 3 when bit 1 (error) is also raised by an unsupported transaction.
- R4: The command fields are: bit 30 write-not-read, bits 29:26 controller, bits 25:20 function, bits 17:16 site, bits 15:12 stack position, bits 11:0 device. A controller other than 0 is an error. So is a stack position other than 0, or a site other than 0 (motherboard) or 1 (daughterboard).
- R5: Function 1 reads or writes an oscillator entry: site 0 devices 0 to 5, or site 1 devices below the daughterboard oscillator count. A device beyond either range is an error.
- R6: A read with function 2 on site 1 returns the voltage parameter of a sensor below the sensor count. On site 0 device 0 it returns 3,300,000. Any other target is an error, and a write with function 2 is always an error.
- R7: A write of function 8 to site 0 device 0 raises shutdown_req for exactly the one cycle after the launch edge. Function 9 on the same target raises reboot_req the same way. Functions 7 and 11 on that target complete without error and with no effect. The same functions on any other target are errors and pulse nothing.
- R8: The data register lives at 0xA0 and is fully writable. A successful read loads its result into it. A write leaves it unchanged. A failed read leaves it unchanged.
- R9: A write to the status register stores only bits 1:0 of the written value.
- R10: With the feature disabled by parameter, all three offsets read zero and ignore writes, and no request pulse is ever produced.
- R11: Any offset other than the three registers reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
Read data is combinational from the registers. Every register write, including a whole transaction, takes effect at the clock edge that samples the strobe. The status and data results of a launch are therefore due in the cycle right after the launch edge. The request pulses are registered at that same edge and fall one cycle later. The bench drives each access at a falling edge and holds it across exactly one rising edge. It samples read data a quarter period after the next falling edge, and it checks each pulse at the first falling edge after launch and again one cycle later.

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl #(
  parameter bit FEATURE_EN = 1'b1,
  parameter int ADDR_W = 12,
  parameter int DB_OSC_NUM = 2,
  parameter int DB_VSENS_NUM = 2,
  parameter logic [DB_OSC_NUM*32-1:0] DB_OSC_RST = {32'd30000000, 32'd25000000},
  parameter logic [DB_VSENS_NUM*32-1:0] DB_VSENS_VAL = {32'd1000000, 32'd900000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              shutdown_req,
  output logic              reboot_req
);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(12'hA0);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(12'hA4);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(12'hA8);
  localparam int MB_N = 6;
  localparam int DBO_W = (DB_OSC_NUM > 1) ? $clog2(DB_OSC_NUM) : 1;
  localparam int DBV_W = (DB_VSENS_NUM > 1) ? $clog2(DB_VSENS_NUM) : 1;
  localparam logic [11:0] MB_LIM = 12'(MB_N);
  localparam logic [11:0] DBO_LIM = 12'(DB_OSC_NUM);
  localparam logic [11:0] DBV_LIM = 12'(DB_VSENS_NUM);
  localparam logic [31:0] MB_VIO = 32'd3300000;
  localparam logic [31:0] CTRL_KEEP = ~32'h800C_0000;
  localparam logic [31:0] MB_RST [MB_N] = '{32'd50000000, 32'd23750000, 32'd24000000,
                                            32'd24000000, 32'd24000000, 32'd24000000};

  logic [31:0] data_q, ctrl_q;
  logic [1:0]  stat_q;
  logic [31:0] mb_osc [MB_N];
  logic [31:0] db_osc [DB_OSC_NUM];
  logic [31:0] db_volt [DB_VSENS_NUM];
  logic        shut_q, reb_q;

  for (genvar g = 0; g < DB_VSENS_NUM; g++) begin : g_volt
    assign db_volt[g] = DB_VSENS_VAL[g*32 +: 32];
  end

  wire sel_data = (bus_addr == OFF_DATA);
  wire sel_ctrl = (bus_addr == OFF_CTRL);
  wire sel_stat = (bus_addr == OFF_STAT);
  wire go       = FEATURE_EN && bus_wr && sel_ctrl && bus_wdata[31];

  wire        t_wr = bus_wdata[30];
  wire [3:0]  dcc  = bus_wdata[29:26];
  wire [5:0]  fn   = bus_wdata[25:20];
  wire [1:0]  site = bus_wdata[17:16];
  wire [3:0]  pos  = bus_wdata[15:12];
  wire [11:0] dev  = bus_wdata[11:0];

  wire base_ok = (dcc == 4'd0) && (pos == 4'd0) && (site[1] == 1'b0);
  wire on_mb   = base_ok && (site == 2'd0);
  wire on_db   = base_ok && (site == 2'd1);
  wire dev0    = (dev == 12'd0);
  wire mb_hit  = on_mb && (dev < MB_LIM);
  wire dbo_hit = on_db && (dev < DBO_LIM);
  wire dbv_hit = on_db && (dev < DBV_LIM);

  wire [2:0]       mb_idx  = dev[2:0];
  wire [DBO_W-1:0] dbo_idx = dev[DBO_W-1:0];
  wire [DBV_W-1:0] dbv_idx = dev[DBV_W-1:0];

  logic        ok, mb_we, dbo_we, shut_n, reb_n;
  logic [31:0] rd_val;

  always_comb begin
    ok = 1'b0; rd_val = '0; mb_we = 1'b0; dbo_we = 1'b0; shut_n = 1'b0; reb_n = 1'b0;
    if (!t_wr) begin
      case (fn)
        6'd1: if (mb_hit) begin ok = 1'b1; rd_val = mb_osc[mb_idx]; end
              else if (dbo_hit) begin ok = 1'b1; rd_val = db_osc[dbo_idx]; end
        6'd2: if (dbv_hit) begin ok = 1'b1; rd_val = db_volt[dbv_idx]; end
              else if (on_mb && dev0) begin ok = 1'b1; rd_val = MB_VIO; end
        default: ok = 1'b0;
      endcase
    end else begin
      case (fn)
        6'd1: begin ok = mb_hit || dbo_hit; mb_we = go && mb_hit; dbo_we = go && dbo_hit; end
        6'd7, 6'd11: ok = on_mb && dev0;
        6'd8: begin ok = on_mb && dev0; shut_n = go && on_mb && dev0; end
        6'd9: begin ok = on_mb && dev0; reb_n = go && on_mb && dev0; end
        default: ok = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
      shut_q <= 1'b0;
      reb_q  <= 1'b0;
      for (int i = 0; i < MB_N; i++) mb_osc[i] <= MB_RST[i];
      for (int i = 0; i < DB_OSC_NUM; i++) db_osc[i] <= DB_OSC_RST[i*32 +: 32];
    end else begin
      shut_q <= shut_n;
      reb_q  <= reb_n;
      if (FEATURE_EN && bus_wr) begin
        if (sel_data) data_q <= bus_wdata;
        if (sel_stat) stat_q <= bus_wdata[1:0];
        if (sel_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
      end
      if (go) begin
        stat_q <= {~ok, 1'b1};
        if (!t_wr && ok) data_q <= rd_val;
      end
      if (mb_we) mb_osc[mb_idx] <= data_q;
      if (dbo_we) db_osc[dbo_idx] <= data_q;
    end
  end

  assign shutdown_req = shut_q;
  assign reboot_req   = reb_q;
  assign bus_rdata = !FEATURE_EN ? 32'd0 :
                     sel_data ? data_q :
                     sel_ctrl ? ctrl_q :
                     sel_stat ? {30'd0, stat_q} : 32'd0;

  if (FEATURE_EN) begin : g_ast
    AST_LAUNCH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ctrl |-> !bus_rdata[31]); // R2
    AST_DONE_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> stat_q[0]); // R3
    AST_BAD_CTRL_ERRS: assert property (@(posedge clk) disable iff (!rst_n)
      (go && dcc != 4'd0) |=> (stat_q == 2'b11)); // R4
    AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |-> $past(bus_wr && sel_ctrl && bus_wdata[31:30] == 2'b11 && bus_wdata[25:20] == 6'd8)); // R7
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(shutdown_req && reboot_req)); // R7
    AST_STAT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_stat) |=> (stat_q == $past(bus_wdata[1:0]))); // R9
  end else begin : g_ast_off
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata == 32'd0) && !shutdown_req && !reboot_req); // R10
  end
endmodule

// File: tb/sim_cfg_txn_ctrl.sv
module sim_cfg_txn_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] pre;
    logic [1:0]  stat;
    logic [31:0] dat;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] mk(input logic w, input logic [3:0] dcc, input logic [5:0] fn,
                                      input logic [1:0] site, input logic [3:0] pos, input logic [11:0] dev);
    return {1'b1, w, dcc, fn, 2'b00, site, pos, dev};
  endfunction

  localparam vec_t VEC [23] = '{
    '{mk(0,0,1,0,0,0),  32'h0,         2'd1, 32'd50000000, 4'd5},  // R5 R1
    '{mk(0,0,1,0,0,1),  32'h0,         2'd1, 32'd23750000, 4'd5},  // R5 R1
    '{mk(0,0,1,0,0,5),  32'h0,         2'd1, 32'd24000000, 4'd5},  // R5 R1
    '{mk(0,0,1,0,0,6),  32'hDEAD0001,  2'd3, 32'hDEAD0001, 4'd8},  // R8 failed read keeps data
    '{mk(0,0,1,1,0,1),  32'h0,         2'd1, 32'h02000000, 4'd5},  // R5 R1
    '{mk(0,0,1,1,0,2),  32'hDEAD0002,  2'd3, 32'hDEAD0002, 4'd5},  // R5
    '{mk(1,0,1,0,0,3),  32'h12345678,  2'd1, 32'h12345678, 4'd8},  // R8 write keeps data
    '{mk(0,0,1,0,0,3),  32'h0,         2'd1, 32'h12345678, 4'd5},  // R5
    '{mk(1,0,1,1,0,0),  32'hCAFE0000,  2'd1, 32'hCAFE0000, 4'd5},  // R5
    '{mk(0,0,1,1,0,0),  32'h0,         2'd1, 32'hCAFE0000, 4'd5},  // R5
    '{mk(0,0,2,0,0,0),  32'h0,         2'd1, 32'd3300000,  4'd6},  // R6
    '{mk(0,0,2,0,0,1),  32'hDEAD0003,  2'd3, 32'hDEAD0003, 4'd6},  // R6
    '{mk(0,0,2,1,0,2),  32'h0,         2'd1, 32'd1200000,  4'd6},  // R6
    '{mk(0,0,2,1,0,3),  32'hDEAD0004,  2'd3, 32'hDEAD0004, 4'd6},  // R6
    '{mk(0,1,1,0,0,0),  32'hDEAD0005,  2'd3, 32'hDEAD0005, 4'd4},  // R4
    '{mk(0,0,1,0,1,0),  32'hDEAD0006,  2'd3, 32'hDEAD0006, 4'd4},  // R4
    '{mk(0,0,1,2,0,0),  32'hDEAD0007,  2'd3, 32'hDEAD0007, 4'd4},  // R4
    '{mk(0,0,3,0,0,0),  32'hDEAD0008,  2'd3, 32'hDEAD0008, 4'd4},  // R4
    '{mk(1,0,2,0,0,0),  32'hDEAD0009,  2'd3, 32'hDEAD0009, 4'd6},  // R6
    '{mk(1,0,7,0,0,0),  32'h0000000A,  2'd1, 32'h0000000A, 4'd7},  // R7
    '{mk(1,0,11,0,0,0), 32'h0000000B,  2'd1, 32'h0000000B, 4'd7},  // R7
    '{mk(1,0,11,0,0,1), 32'h0000000C,  2'd3, 32'h0000000C, 4'd7},  // R7
    '{mk(1,0,7,1,0,0),  32'h0000000D,  2'd3, 32'h0000000D, 4'd7}   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr0 = 1'b0, wr1 = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        shut0, reb0, shut1, reb1;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_txn_ctrl #(.DB_OSC_NUM(2), .DB_VSENS_NUM(3),
    .DB_OSC_RST({32'h02000000, 32'h01000000}),
    .DB_VSENS_VAL({32'd1200000, 32'd1100000, 32'd1000000})) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr0), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata0), .shutdown_req(shut0), .reboot_req(reb0));

  cfg_txn_ctrl #(.FEATURE_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr1), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata1), .shutdown_req(shut1), .reboot_req(reb1));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit which, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (which) wr1 = 1'b1; else wr0 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(input bit which, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #(CLK_PERIOD/4);
    d = which ? rdata1 : rdata0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 12'hA0, v); chk("R1 data", v, 32'd0);
    rd(0, 12'hA4, v); chk("R1 ctrl", v, 32'd0);
    rd(0, 12'hA8, v); chk("R1 stat", v, 32'd0);
    chk("R1 pulses", {30'd0, shut0, reb0}, 32'd0);

    for (int i = 0; i < 23; i++) begin
      wr(0, 12'hA0, VEC[i].pre);
      wr(0, 12'hA4, VEC[i].ctrl);
      rd(0, 12'hA8, v); chk($sformatf("R%0d stat vec%0d", VEC[i].req, i), v, {30'd0, VEC[i].stat});
      rd(0, 12'hA0, v); chk($sformatf("R%0d data vec%0d", VEC[i].req, i), v, VEC[i].dat);
    end

    // R2 masking and no launch without bit 31
    wr(0, 12'hA8, 32'h0);
    wr(0, 12'hA4, 32'h7FFFFFFF);
    rd(0, 12'hA4, v); chk("R2 ctrl mask", v, 32'h7FF3FFFF);
    rd(0, 12'hA8, v); chk("R2 no launch", v, 32'd0);
    wr(0, 12'hA4, 32'hFFFFFFFF);
    rd(0, 12'hA4, v); chk("R2 launch bit clears", v, 32'h7FF3FFFF);
    rd(0, 12'hA8, v); chk("R3 R4 bad ctrl", v, 32'd3);

    // R9 status write
    wr(0, 12'hA8, 32'hFFFFFFFE);
    rd(0, 12'hA8, v); chk("R9 stat keep", v, 32'd2);
    wr(0, 12'hA8, 32'h00000005);
    rd(0, 12'hA8, v); chk("R9 stat keep", v, 32'd1);

    // R7 shutdown and reboot pulses
    wr(0, 12'hA4, mk(1,0,8,0,0,0));
    chk("R7 shutdown high", {31'd0, shut0}, 32'd1);
    chk("R7 reboot idle", {31'd0, reb0}, 32'd0);
    @(negedge clk);
    chk("R7 shutdown low", {31'd0, shut0}, 32'd0);
    wr(0, 12'hA4, mk(1,0,9,0,0,0));
    chk("R7 reboot high", {31'd0, reb0}, 32'd1);
    chk("R7 shutdown idle", {31'd0, shut0}, 32'd0);
    @(negedge clk);
    chk("R7 reboot low", {31'd0, reb0}, 32'd0);
    wr(0, 12'hA4, mk(1,0,9,1,0,0));
    chk("R7 bad site no pulse", {30'd0, shut0, reb0}, 32'd0);
    rd(0, 12'hA8, v); chk("R7 bad site err", v, 32'd3);

    // R11 unmapped offset
    rd(0, 12'hAC, v); chk("R11 unmapped", v, 32'd0);

    // R10 disabled variant
    wr(1, 12'hA0, 32'h55555555);
    rd(1, 12'hA0, v); chk("R10 data", v, 32'd0);
    wr(1, 12'hA4, mk(1,0,9,0,0,0));
    chk("R10 no pulse", {30'd0, shut1, reb1}, 32'd0);
    rd(1, 12'hA4, v); chk("R10 ctrl", v, 32'd0);
    rd(1, 12'hA8, v); chk("R10 stat", v, 32'd0);

    finish_run();
  end
endmodule